// File: doc/BRIEF.md
# Two-Bank Byte Address Pointer

This block holds the current byte address for a serial memory of 4 Kbit arranged as two banks of 2 Kbit. Only one bank can be addressed at any moment. The bank is not chosen through address bits. Separate command strobes choose it: one selects the lower bank, one selects the upper bank, and a third asks which bank is active. The answer to that query comes back on a response output one cycle later.

The bus front end drives the pointer strobes. A load strobe sets the starting byte of a selective read or a write. An increment strobe moves the pointer forward after each byte is transferred. When the pointer steps past the last byte of the active bank, it returns to byte 0 of that same bank, so a sequential read never crosses into the other bank. The block combines the bank bit and the byte pointer into the physical array address.

When the memory reports that a nonvolatile write is in progress, bank-select commands are dropped.

Top module: `banked_addr_ptr`

## Requirements
- R1: After reset the byte pointer is 0x00, the lower bank is active (`bank_o` = 0), and `bank_rsp_valid_o` is 0.
- R2: A `sel_hi_i` strobe with `sel_lo_i` low and `wr_busy_i` low makes `bank_o` read 1 from the next cycle.
- R3: A `sel_lo_i` strobe with `wr_busy_i` low makes `bank_o` read 0 from the next cycle.
- R4: Any select strobe that arrives while `wr_busy_i` is high is ignored, so `bank_o` keeps its value.
- R5: If `sel_lo_i` and `sel_hi_i` arrive together while `wr_busy_i` is low, the lower bank is selected.
- R6: A `rd_bank_i` strobe makes `bank_rsp_valid_o` 1 in the next cycle. In that cycle `bank_rsp_o` carries the bank that was active at the clock edge, before any select taking effect at the same edge. With no `rd_bank_i`, `bank_rsp_valid_o` is 0.
- R7: A `load_i` strobe makes the pointer equal to `load_addr_i` from the next cycle.
- R8: An `incr_i` strobe without `load_i` advances the pointer by one.
- R9: Incrementing from 0xFF gives 0x00 and leaves the active bank unchanged.
- R10: When `load_i` and `incr_i` are high in the same cycle, the load takes effect and the increment is discarded.
- R11: `phys_addr_o` equals {`bank_o`, pointer}, with the bank in bit 8 and the pointer in bits 7:0.
- R12: When neither `load_i` nor `incr_i` is high, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_lo_i | input | 1 | Select-lower-bank command strobe |
| sel_hi_i | input | 1 | Select-upper-bank command strobe |
| rd_bank_i | input | 1 | Query the active bank |
| wr_busy_i | input | 1 | Nonvolatile write in progress |
| load_i | input | 1 | Load the byte pointer |
| load_addr_i | input | 8 | Byte address to load |
| incr_i | input | 1 | Advance the pointer after a byte |
| phys_addr_o | output | 9 | Physical array address {bank, pointer} |
| bank_o | output | 1 | Active bank (0 lower, 1 upper) |
| bank_rsp_valid_o | output | 1 | Bank query response valid |
| bank_rsp_o | output | 1 | Bank reported by the query |

## Verification
Several pairs of functions can fall in the same cycle. A load can coincide with an increment. A bank query can coincide with a bank select. An increment can coincide with a select while a write is busy. Each pair is provoked by driving both strobes in a single stimulus step. The scoreboard model applies the stated priorities: the load wins over the increment, the query reports the bank held before the edge, and the busy flag blocks the select but not the pointer. The bench then compares the resulting pointer, bank and response against the model on the following cycle.

// File: rtl/banked_addr_ptr_pkg.sv
package banked_addr_ptr_pkg;

  typedef enum logic {
    BANK_LOWER = 1'b0,
    BANK_UPPER = 1'b1
  } bank_e;

  typedef struct packed {
    logic sel_lo;
    logic sel_hi;
    logic rd_bank;
  } bank_cmd_t;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_INCR = 2'd2
  } ptr_op_e;

endpackage

// File: rtl/bank_sel_ctrl.sv
module bank_sel_ctrl
  import banked_addr_ptr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bank_cmd_t cmd_i,
  input  logic      wr_busy_i,
  output bank_e     bank_o,
  output logic      rsp_valid_o,
  output bank_e     rsp_bank_o
);

  bank_e bank_q, bank_d;
  logic  rsp_valid_q;
  bank_e rsp_bank_q;

  // lower select has priority; busy blocks both
  always_comb begin
    bank_d = bank_q;
    if (!wr_busy_i) begin
      if (cmd_i.sel_lo)      bank_d = BANK_LOWER;
      else if (cmd_i.sel_hi) bank_d = BANK_UPPER;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q      <= BANK_LOWER;
      rsp_valid_q <= 1'b0;
      rsp_bank_q  <= BANK_LOWER;
    end else begin
      bank_q      <= bank_d;
      rsp_valid_q <= cmd_i.rd_bank;
      if (cmd_i.rd_bank) rsp_bank_q <= bank_q;
    end
  end

  assign bank_o      = bank_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_bank_o  = rsp_bank_q;

  AST_SEL_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.sel_hi && !cmd_i.sel_lo && !wr_busy_i) |=> bank_o == BANK_UPPER); // R2
  AST_SEL_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.sel_lo && !wr_busy_i) |=> bank_o == BANK_LOWER); // R3
  AST_BUSY_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_i |=> $stable(bank_o)); // R4
  AST_DUAL_SEL_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.sel_lo && cmd_i.sel_hi && !wr_busy_i) |=> bank_o == BANK_LOWER); // R5
  AST_QUERY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rd_bank |=> (rsp_valid_o && rsp_bank_o == $past(bank_o))); // R6
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i.rd_bank |=> !rsp_valid_o); // R6

endmodule

// File: rtl/byte_ptr_ctr.sv
module byte_ptr_ctr
  import banked_addr_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_addr_i,
  input  logic             incr_i,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] PtrOne = PTR_W'(1);

  ptr_op_e          op;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  // load beats increment
  always_comb begin
    if (load_i)      op = PTR_LOAD;
    else if (incr_i) op = PTR_INCR;
    else             op = PTR_HOLD;
  end

  // natural modulo wrap keeps the pointer inside one bank
  always_comb begin
    unique case (op)
      PTR_LOAD: ptr_d = load_addr_i;
      PTR_INCR: ptr_d = ptr_q + PtrOne;
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_o == $past(load_addr_i)); // R7 R10
  AST_INCR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i) |=> ptr_o == PTR_W'($past(ptr_o) + 1'b1)); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i && (&ptr_o)) |=> ptr_o == '0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!incr_i && !load_i) |=> $stable(ptr_o)); // R12

endmodule

// File: rtl/banked_addr_ptr.sv
module banked_addr_ptr
  import banked_addr_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 8,
  localparam int unsigned PHYS_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_lo_i,
  input  logic              sel_hi_i,
  input  logic              rd_bank_i,
  input  logic              wr_busy_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  load_addr_i,
  input  logic              incr_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              bank_o,
  output logic              bank_rsp_valid_o,
  output logic              bank_rsp_o
);

  bank_cmd_t        cmd;
  bank_e            bank, rsp_bank;
  logic [PTR_W-1:0] ptr;

  assign cmd = '{sel_lo: sel_lo_i, sel_hi: sel_hi_i, rd_bank: rd_bank_i};

  bank_sel_ctrl u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .wr_busy_i   (wr_busy_i),
    .bank_o      (bank),
    .rsp_valid_o (bank_rsp_valid_o),
    .rsp_bank_o  (rsp_bank)
  );

  byte_ptr_ctr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .incr_i      (incr_i),
    .ptr_o       (ptr)
  );

  assign phys_addr_o = {bank, ptr};
  assign bank_o      = bank;
  assign bank_rsp_o  = rsp_bank;

  // bank bit survives a pointer wrap
  AST_WRAP_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i && !sel_lo_i && !sel_hi_i) |=> $stable(bank_o)); // R9
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (phys_addr_o == '0 && !bank_rsp_valid_o)); // R1

endmodule

// File: tb/banked_addr_ptr_tb.sv
module banked_addr_ptr_tb_top;

  typedef struct {
    logic [7:0] ptr;
    logic       bank;
    logic       rsp_valid;
    logic       rsp_bank;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_lo = 1'b0, sel_hi = 1'b0, rd_bank = 1'b0, busy = 1'b0;
  logic       load = 1'b0, incr = 1'b0;
  logic [7:0] laddr = '0;
  logic [8:0] phys;
  logic       bank, rsp_valid, rsp_bank;

  int   checks = 0;
  int   fails  = 0;
  exp_t sb_q[$];
  logic m_bank = 1'b0;
  logic [7:0] m_ptr = '0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  banked_addr_ptr dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .sel_lo_i         (sel_lo),
    .sel_hi_i         (sel_hi),
    .rd_bank_i        (rd_bank),
    .wr_busy_i        (busy),
    .load_i           (load),
    .load_addr_i      (laddr),
    .incr_i           (incr),
    .phys_addr_o      (phys),
    .bank_o           (bank),
    .bank_rsp_valid_o (rsp_valid),
    .bank_rsp_o       (rsp_bank)
  );

  task automatic step(input logic lo, input logic hi, input logic rd,
                      input logic ld, input logic [7:0] a, input logic inc,
                      input logic bsy, input string tag);
    exp_t e;
    @(negedge clk);
    sel_lo = lo; sel_hi = hi; rd_bank = rd; load = ld; laddr = a;
    incr = inc; busy = bsy;
    e.rsp_valid = rd;
    e.rsp_bank  = m_bank;
    if (!bsy) begin
      if (lo)      m_bank = 1'b0;
      else if (hi) m_bank = 1'b1;
    end
    if (ld)       m_ptr = a;
    else if (inc) m_ptr = m_ptr + 8'd1;
    e.ptr  = m_ptr;
    e.bank = m_bank;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // monitor: result of each step is visible just after the following edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (phys !== {e.bank, e.ptr} || bank !== e.bank ||
          rsp_valid !== e.rsp_valid || (e.rsp_valid && rsp_bank !== e.rsp_bank)) begin
        fails++;
        $display("FAIL %s: phys=%h bank=%b rspv=%b rsp=%b expected phys=%h bank=%b rspv=%b rsp=%b",
                 e.tag, phys, bank, rsp_valid, rsp_bank,
                 {e.bank, e.ptr}, e.bank, e.rsp_valid, e.rsp_bank);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #23;
    checks++;
    if (phys !== 9'h000 || bank !== 1'b0 || rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: phys=%h bank=%b rspv=%b expected 000 0 0", phys, bank, rsp_valid);
    end
    rst_n = 1'b1;
    step(0,0,1,0,8'h00,0,0, "R1 R6 query after reset");
    step(0,0,0,1,8'h10,0,0, "R7 load 10");
    step(0,0,0,0,8'h00,1,0, "R8 incr");
    step(0,0,0,0,8'h00,1,0, "R8 incr");
    step(0,0,0,0,8'h00,0,0, "R12 hold");
    step(0,1,0,0,8'h00,0,0, "R2 select upper");
    step(0,0,1,0,8'h00,0,0, "R6 query upper");
    step(0,0,0,1,8'hFE,0,0, "R7 R11 load FE upper");
    step(0,0,0,0,8'h00,1,0, "R8 incr to FF");
    step(0,0,0,0,8'h00,1,0, "R9 wrap to 00 in upper");
    step(0,0,0,0,8'h00,1,0, "R9 continue after wrap");
    step(1,0,0,0,8'h00,1,1, "R4 lower ignored while busy");
    step(1,0,0,0,8'h00,0,0, "R3 select lower");
    step(0,1,0,0,8'h00,1,1, "R4 upper ignored while busy with incr");
    step(1,1,0,0,8'h00,0,0, "R5 both selects");
    step(0,0,0,1,8'h42,1,0, "R10 load beats incr");
    step(0,1,1,0,8'h00,0,0, "R6 query with select same edge");
    step(0,0,1,0,8'h00,0,0, "R6 query reports upper");
    step(0,0,0,1,8'hFF,0,0, "R7 load FF");
    step(0,0,0,0,8'h00,1,0, "R9 wrap upper FF");
    step(1,0,0,0,8'h00,0,0, "R3 back to lower");
    step(0,0,0,1,8'hFF,0,0, "R7 load FF lower");
    step(0,0,0,0,8'h00,1,0, "R9 wrap lower FF");
    step(0,0,0,0,8'h00,0,0, "R12 idle hold");
    step(0,0,0,0,8'h00,0,0, "R12 idle hold");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule